// File: doc/BRIEF.md
# Polyphase Horizontal Line Resampler

This block stretches or shrinks one line of 8-bit video samples from a programmed source width to a programmed destination width. A whole source line is collected into a line store first. The block then emits the destination pixels one at a time. Each output pixel comes from a 9-tap FIR filter centred on the source position that the output maps to. The filter coefficients are picked by the 5-bit sub-pixel phase of that position.

Software sets up the block through a small write-only register port. The port holds the two widths, a 16.16 source step per output pixel, and a word pointer into the coefficient store. A data register takes two signed Q2.14 coefficients per 32-bit write. Only phases 0 through 16 are stored. Phases 17 through 31 reuse a mirrored stored phase with the taps read in reverse order.

When both widths are equal, the block forwards the line unchanged and does not touch the filter. Pixels enter and leave on valid/ready streams. While the last pixel of a line is still waiting on the output, the block already accepts the next line.

Top module: `scl_hscale`

## Requirements
- R1: After reset, `out_valid` is 0 and `in_ready` is 1.
- R2: A register write goes to `cfg_addr` 0 for the source width, 1 for the destination width, 2 for the 16.16 source step, 3 for the coefficient word pointer, and 4 for the coefficient data port.
- R3: A data-port write at word pointer w stores `cfg_wdata[15:0]` as coefficient 2w and `cfg_wdata[31:16]` as coefficient 2w+1. Coefficient k belongs to stored phase k/9, tap k%9, and indices of 153 and above are dropped. The pointer then advances by one.
- R4: A write to the pointer register sets the pointer to `cfg_wdata[6:0]`. The next data write lands there.
- R5: Exactly source-width pixels are accepted per line, with `in_ready` high only while a line is being collected. Exactly destination-width pixels are then produced.
- R6: Output pixel j uses position j*step. Its integer part is the centre source index, and fractional bits [15:11] are the phase.
- R7: Tap t (0..8) reads source pixel centre+t-4. An index below 0 uses pixel 0, and an index past the line end uses the last pixel.
- R8: A phase p of 16 or less uses stored phase p with tap t. A phase p above 16 uses stored phase 32-p with tap 8-t. Coefficients are signed, and 0x4000 means 1.0.
- R9: The 9 products, plus 8192, are shifted arithmetically right by 14 bits. The result is then clamped to the range 0 to 255.
- R10: When the source width equals the destination width, output j equals input j whatever the table holds.
- R11: While `out_valid` is high and `out_ready` is low, `out_valid` and `out_data` hold.
- R12: A table write made while an output is stalled does not change the held pixel. It applies to every pixel computed afterwards.
- R13: While the last pixel of a line waits on the output, the next line is accepted, and the waiting pixel is kept.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_addr | input | 3 | Register select |
| cfg_wdata | input | 32 | Register write data |
| in_valid | input | 1 | Source pixel valid |
| in_ready | output | 1 | Source pixel accepted when high with in_valid |
| in_data | input | 8 | Source pixel |
| out_valid | output | 1 | Scaled pixel valid |
| out_ready | input | 1 | Downstream accepts scaled pixel |
| out_data | output | 8 | Scaled pixel |

## Verification
Two functions can fall in the same cycle. The first is the output stall, which holds the finished pixel on `out_data`. The second is either a coefficient-store update or intake of the next line, both of which change what the filter sees. The bench holds `out_ready` low after the first pixel of a line and rewrites the whole table. It checks that the held pixel still matches the old table and that every later pixel matches the new one. In a second scenario it stalls the last pixel of a line and pushes a complete new line past it. It then checks that the stalled value survives and comes out ahead of the new line's pixels.

// File: rtl/scl_pkg.sv
package scl_pkg;
  localparam int PIX_W   = 8;
  localparam int COEF_W  = 16;
  localparam int TAPS    = 9;
  localparam int PH_BITS = 5;
  localparam int PH_HALF = (1 << PH_BITS) / 2;
  localparam int NPH     = PH_HALF + 1;
  localparam int NCOEF   = NPH * TAPS;
  localparam int FRAC    = 16;
  localparam int PTR_W   = 7;
  localparam int CIDX_W  = PTR_W + 1;
  localparam int PROD_W  = COEF_W + PIX_W + 1;
  localparam int SUM_W   = PROD_W + 4;

  typedef enum logic [2:0] {
    A_SRC  = 3'd0,
    A_DST  = 3'd1,
    A_STEP = 3'd2,
    A_IDX  = 3'd3,
    A_DATA = 3'd4
  } cfg_addr_e;

  typedef enum logic {
    ST_LOAD = 1'b0,
    ST_RUN  = 1'b1
  } scl_state_e;
endpackage

// File: rtl/scl_regs.sv
module scl_regs
  import scl_pkg::*;
#(
  parameter int WW = 7,
  parameter int AW = 25
) (
  input  logic                              clk,
  input  logic                              rst,
  input  logic                              we,
  input  logic [2:0]                        addr,
  input  logic [31:0]                       wdata,
  output logic [WW-1:0]                     src_w,
  output logic [WW-1:0]                     dst_w,
  output logic [AW-1:0]                     step,
  output logic [NCOEF-1:0][COEF_W-1:0]      coefs
);
  logic [PTR_W-1:0]  ptr;
  logic [COEF_W-1:0] tab [NCOEF];
  logic [CIDX_W-1:0] lo_idx, hi_idx;

  assign lo_idx = {ptr, 1'b0};
  assign hi_idx = {ptr, 1'b1};

  always_ff @(posedge clk) begin
    if (rst) begin
      src_w <= '0;
      dst_w <= '0;
      step  <= '0;
      ptr   <= '0;
    end else if (we) begin
      case (addr)
        A_SRC:  src_w <= wdata[WW-1:0];
        A_DST:  dst_w <= wdata[WW-1:0];
        A_STEP: step  <= wdata[AW-1:0];
        A_IDX:  ptr   <= wdata[PTR_W-1:0];
        A_DATA: ptr   <= ptr + 1'b1;
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (we && addr == A_DATA) begin
      if (lo_idx < CIDX_W'(NCOEF)) tab[lo_idx] <= wdata[15:0];
      if (hi_idx < CIDX_W'(NCOEF)) tab[hi_idx] <= wdata[31:16];
    end
  end

  for (genvar k = 0; k < NCOEF; k++) begin : g_out
    assign coefs[k] = tab[k];
  end

  // R3
  ptr_step_chk: assert property (@(posedge clk) disable iff (rst)
    (we && addr == A_DATA) |=> ptr == $past(ptr) + 1'b1);

  // R4
  ptr_load_chk: assert property (@(posedge clk) disable iff (rst)
    (we && addr == A_IDX) |=> ptr == $past(wdata[PTR_W-1:0]));
endmodule

// File: rtl/scl_linebuf.sv
module scl_linebuf
  import scl_pkg::*;
#(
  parameter int MAX_W = 64,
  parameter int WW    = 7,
  parameter int IW    = 9
) (
  input  logic                          clk,
  input  logic                          wr_en,
  input  logic [$clog2(MAX_W)-1:0]      wr_addr,
  input  logic [PIX_W-1:0]              wr_data,
  input  logic [IW-1:0]                 centre,
  input  logic [WW-1:0]                 src_w,
  output logic [TAPS-1:0][PIX_W-1:0]    taps
);
  localparam int AIW  = $clog2(MAX_W);
  localparam int SW   = IW + 2;
  localparam int HALF = TAPS / 2;

  logic [PIX_W-1:0] mem [MAX_W];
  logic signed [SW-1:0] last;

  always_ff @(posedge clk) begin
    if (wr_en) mem[wr_addr] <= wr_data;
  end

  assign last = $signed({{(SW-WW){1'b0}}, src_w}) - $signed(SW'(1));

  for (genvar t = 0; t < TAPS; t++) begin : g_tap
    logic signed [SW-1:0] pos;
    logic signed [SW-1:0] sel;
    logic                 unused_sel;
    assign pos = $signed({2'b00, centre}) + $signed(SW'(t - HALF));
    assign sel = (pos < 0) ? '0 : ((pos > last) ? last : pos);
    assign unused_sel = ^sel[SW-1:AIW];
    assign taps[t] = mem[sel[AIW-1:0]];
  end
endmodule

// File: rtl/scl_filter.sv
module scl_filter
  import scl_pkg::*;
(
  input  logic [TAPS-1:0][PIX_W-1:0]   taps,
  input  logic [NCOEF-1:0][COEF_W-1:0] coefs,
  input  logic [PH_BITS-1:0]           phase,
  output logic [PIX_W-1:0]             pix
);
  logic                     rev;
  logic [CIDX_W-1:0]        base;
  logic signed [PROD_W-1:0] prod [TAPS];
  logic signed [SUM_W-1:0]  sum;
  logic signed [SUM_W-1:0]  shifted;

  always_comb begin
    rev  = phase > PH_BITS'(PH_HALF);
    base = rev ? CIDX_W'((2 * PH_HALF - int'(phase)) * TAPS)
               : CIDX_W'(int'(phase) * TAPS);
    sum  = '0;
    for (int t = 0; t < TAPS; t++) begin
      prod[t] = $signed(coefs[base + CIDX_W'(rev ? TAPS - 1 - t : t)])
              * $signed({1'b0, taps[t]});
      sum = sum + {{(SUM_W-PROD_W){prod[t][PROD_W-1]}}, prod[t]};
    end
    sum     = sum + SUM_W'(1 << 13);
    shifted = sum >>> 14;
    if (shifted < 0)                      pix = '0;
    else if (shifted > SUM_W'(255))       pix = '1;
    else                                  pix = shifted[PIX_W-1:0];
  end
endmodule

// File: rtl/scl_hscale.sv
module scl_hscale
  import scl_pkg::*;
#(
  parameter int MAX_W = 64
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        cfg_we,
  input  logic [2:0]  cfg_addr,
  input  logic [31:0] cfg_wdata,
  input  logic        in_valid,
  output logic        in_ready,
  input  logic [7:0]  in_data,
  output logic        out_valid,
  input  logic        out_ready,
  output logic [7:0]  out_data
);
  localparam int WW  = $clog2(MAX_W + 1);
  localparam int AIW = $clog2(MAX_W);
  localparam int AW  = FRAC + WW + 2;
  localparam int IW  = AW - FRAC;

  logic [WW-1:0]                    src_w, dst_w;
  logic [AW-1:0]                    step;
  logic [NCOEF-1:0][COEF_W-1:0]     coefs;
  logic [TAPS-1:0][PIX_W-1:0]       taps;
  logic [PIX_W-1:0]                 filt_pix;
  scl_state_e                       st;
  logic [WW-1:0]                    wr_cnt, out_cnt;
  logic [AW-1:0]                    acc;
  logic                             bypass, take_in, adv;
  logic [IW-1:0]                    centre;
  logic                             unused_cnt;

  scl_regs #(.WW(WW), .AW(AW)) u_regs (
    .clk(clk), .rst(rst), .we(cfg_we), .addr(cfg_addr), .wdata(cfg_wdata),
    .src_w(src_w), .dst_w(dst_w), .step(step), .coefs(coefs)
  );

  assign bypass  = (src_w == dst_w);
  assign centre  = bypass ? IW'(out_cnt) : acc[AW-1:FRAC];
  assign in_ready = (st == ST_LOAD);
  assign take_in = in_valid && in_ready;
  assign adv     = (st == ST_RUN) && (!out_valid || out_ready);
  assign unused_cnt = ^wr_cnt[WW-1:AIW];

  scl_linebuf #(.MAX_W(MAX_W), .WW(WW), .IW(IW)) u_line (
    .clk(clk), .wr_en(take_in), .wr_addr(wr_cnt[AIW-1:0]), .wr_data(in_data),
    .centre(centre), .src_w(src_w), .taps(taps)
  );

  scl_filter u_filt (
    .taps(taps), .coefs(coefs), .phase(acc[FRAC-1:FRAC-PH_BITS]), .pix(filt_pix)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      st        <= ST_LOAD;
      wr_cnt    <= '0;
      out_cnt   <= '0;
      acc       <= '0;
      out_valid <= 1'b0;
      out_data  <= '0;
    end else begin
      if (take_in) begin
        if (wr_cnt == src_w - 1'b1) begin
          st      <= ST_RUN;
          wr_cnt  <= '0;
          out_cnt <= '0;
          acc     <= '0;
        end else begin
          wr_cnt <= wr_cnt + 1'b1;
        end
      end
      if (adv) begin
        out_data  <= bypass ? taps[TAPS/2] : filt_pix;
        out_valid <= 1'b1;
        acc       <= acc + step;
        if (out_cnt == dst_w - 1'b1) st <= ST_LOAD;
        else out_cnt <= out_cnt + 1'b1;
      end else if (out_ready) begin
        out_valid <= 1'b0;
      end
    end
  end

  // R11
  out_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_data)));

  // R5
  line_full_chk: assert property (@(posedge clk) disable iff (rst)
    (take_in && wr_cnt == src_w - 1'b1) |=> !in_ready);
endmodule

// File: tb/scl_hscale_tb.sv
module scl_hscale_tb;
  logic        clk = 1'b0;
  logic        rst;
  logic        cfg_we;
  logic [2:0]  cfg_addr;
  logic [31:0] cfg_wdata;
  logic        in_valid;
  logic        in_ready;
  logic [7:0]  in_data;
  logic        out_valid;
  logic        out_ready;
  logic [7:0]  out_data;

  int checks = 0;
  int errors = 0;
  int cyc = 0;
  int tb_tab [153];
  int line_px [64];
  int got [64];
  int cur_src, cur_dst, cur_step;

  always #4 clk = ~clk;

  scl_hscale u_dut (
    .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata),
    .in_valid(in_valid), .in_ready(in_ready), .in_data(in_data),
    .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data)
  );

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      errors++;
      $display("FAIL watchdog: run did not finish");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  task automatic chk(input int act, input int exp, input string req);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic cfg(input int a, input logic [31:0] d);
    cfg_we = 1'b1; cfg_addr = 3'(a); cfg_wdata = d;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic set_geom(input int s, input int d);
    cur_src = s; cur_dst = d;
    cur_step = (s == d) ? 65536 : ((s - 1) * 65536) / (d - 1);
    cfg(0, 32'(s)); cfg(1, 32'(d)); cfg(2, 32'(cur_step));
  endtask

  task automatic load_table();
    cfg(3, 32'd0);
    for (int w = 0; w < 128; w++) begin
      int lo, hi;
      lo = (2 * w < 153) ? tb_tab[2 * w] : 0;
      hi = (2 * w + 1 < 153) ? tb_tab[2 * w + 1] : 0;
      cfg(4, {16'(hi), 16'(lo)});
    end
  endtask

  task automatic send_line(input int n);
    for (int k = 0; k < n; k++) begin
      in_valid = 1'b1; in_data = 8'(line_px[k]);
      while (!in_ready) @(negedge clk);
      @(negedge clk);
    end
    in_valid = 1'b0;
  endtask

  task automatic collect(input int n);
    int cnt;
    cnt = 0;
    out_ready = 1'b1;
    while (cnt < n) begin
      if (out_valid) begin got[cnt] = int'(out_data); cnt++; end
      @(negedge clk);
    end
  endtask

  function automatic int model(input int j);
    int acc, i, p, sum, pos, c, r;
    if (cur_src == cur_dst) return line_px[j];
    acc = j * cur_step; i = acc >>> 16; p = (acc >>> 11) & 31; sum = 0;
    for (int t = 0; t < 9; t++) begin
      pos = i + t - 4;
      if (pos < 0) pos = 0;
      if (pos > cur_src - 1) pos = cur_src - 1;
      c = (p <= 16) ? tb_tab[p * 9 + t] : tb_tab[(32 - p) * 9 + 8 - t];
      sum += c * line_px[pos];
    end
    r = (sum + 8192) >>> 14;
    if (r < 0) r = 0;
    if (r > 255) r = 255;
    return r;
  endfunction

  task automatic centre_table();
    for (int k = 0; k < 153; k++) tb_tab[k] = (k % 9 == 4) ? 16384 : 0;
  endtask

  task automatic mixed_table();
    for (int k = 0; k < 153; k++) tb_tab[k] = ((k * 2749 + 311) % 9000) - 2500;
  endtask

  task automatic run_and_compare(input string req);
    send_line(cur_src);
    collect(cur_dst);
    for (int j = 0; j < cur_dst; j++) chk(got[j], model(j), req);
  endtask

  task automatic t_reset();
    chk(int'(out_valid), 0, "R1 out_valid");
    chk(int'(in_ready), 1, "R1 in_ready");
  endtask

  task automatic t_bypass();
    set_geom(8, 8);
    for (int k = 0; k < 8; k++) line_px[k] = (k * 31 + 7) & 255;
    send_line(8);
    collect(8);
    for (int j = 0; j < 8; j++) chk(got[j], line_px[j], "R10 bypass");
  endtask

  task automatic t_downscale();
    centre_table();
    load_table();
    set_geom(16, 7);
    for (int k = 0; k < 16; k++) line_px[k] = (k * 53 + 11) & 255;
    run_and_compare("R6 R2 R5 downscale");
  endtask

  task automatic t_mixed();
    mixed_table();
    load_table();
    set_geom(8, 21);
    line_px[0] = 0;  line_px[1] = 255; line_px[2] = 17; line_px[3] = 200;
    line_px[4] = 90; line_px[5] = 255; line_px[6] = 0;  line_px[7] = 128;
    run_and_compare("R3 R7 R8 upscale");
  endtask

  task automatic t_clamp();
    // phase 0: tap4 = 0x7FFF, tap5 = 0xC000 (-1.0); expected 255, 0, 250
    for (int k = 0; k < 153; k++) tb_tab[k] = 0;
    tb_tab[4] = 32767; tb_tab[5] = -16384;
    load_table();
    set_geom(5, 3);
    line_px[0] = 250; line_px[1] = 0; line_px[2] = 0; line_px[3] = 250; line_px[4] = 250;
    run_and_compare("R9 clamp");
    chk(got[0], 255, "R9 upper clamp");
    chk(got[1], 0, "R9 lower clamp");
  endtask

  task automatic t_index();
    mixed_table();
    load_table();
    cfg(3, 32'd2);
    cfg(4, {16'(-3000), 16'(12000)});
    cfg(4, {16'(700), 16'(-900)});
    tb_tab[4] = 12000; tb_tab[5] = -3000; tb_tab[6] = -900; tb_tab[7] = 700;
    set_geom(8, 21);
    line_px[0] = 40; line_px[1] = 220; line_px[2] = 5;   line_px[3] = 180;
    line_px[4] = 60; line_px[5] = 130; line_px[6] = 250; line_px[7] = 3;
    run_and_compare("R4 index");
  endtask

  task automatic t_stall_write();
    int exp0;
    mixed_table();
    load_table();
    set_geom(8, 21);
    for (int k = 0; k < 8; k++) line_px[k] = (k * 77 + 19) & 255;
    exp0 = model(0);
    out_ready = 1'b0;
    send_line(8);
    while (!out_valid) @(negedge clk);
    for (int h = 0; h < 3; h++) begin
      chk(int'(out_valid), 1, "R11 valid held");
      chk(int'(out_data), exp0, "R11 data held");
      @(negedge clk);
    end
    centre_table();
    load_table();
    chk(int'(out_data), exp0, "R12 held pixel after table write");
    collect(21);
    chk(got[0], exp0, "R12 first pixel");
    for (int j = 1; j < 21; j++) chk(got[j], model(j), "R12 new table");
  endtask

  task automatic t_overlap();
    int last_exp;
    mixed_table();
    load_table();
    set_geom(6, 4);
    for (int k = 0; k < 6; k++) line_px[k] = (k * 91 + 33) & 255;
    send_line(6);
    collect(3);
    for (int j = 0; j < 3; j++) chk(got[j], model(j), "R13 line one");
    last_exp = model(3);
    out_ready = 1'b0;
    while (!out_valid) @(negedge clk);
    chk(int'(in_ready), 1, "R13 ready while last pending");
    for (int k = 0; k < 6; k++) line_px[k] = (k * 29 + 140) & 255;
    send_line(6);
    chk(int'(out_valid), 1, "R13 last still valid");
    chk(int'(out_data), last_exp, "R13 last kept");
    collect(5);
    chk(got[0], last_exp, "R13 last emitted");
    for (int j = 0; j < 4; j++) chk(got[j + 1], model(j), "R13 line two");
  endtask

  initial begin
    rst = 1'b1; cfg_we = 1'b0; cfg_addr = '0; cfg_wdata = '0;
    in_valid = 1'b0; in_data = '0; out_ready = 1'b0;
    repeat (4) @(negedge clk);
    rst = 1'b0;
    t_reset();
    t_bypass();
    t_downscale();
    t_mixed();
    t_clamp();
    t_index();
    t_stall_write();
    t_overlap();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule